// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block steps one switchable power domain between its on and off states when a single request pulse arrives. For power-down it holds the domain's clocks running. It then asks for the bus QoS context to be saved and sends the domain's bus interface into idle. Only after that does it open the power switch and wait for the switch status to agree. Power-up runs the same phases in the opposite order: close the switch, wait for status, take the bus interface out of idle, restore QoS context, and release the clocks. The settling time after a switch change comes from one of two programmable counts, one for each direction. A status that never follows the switch ends the sequence with a fault flag.

The QoS store, the bus idle logic and the power switch sit outside the block and answer through simple handshake inputs. Parameters describe which controls the domain actually has. A domain without a switch only moves its bus interface in and out of idle. A domain without a status bit works out whether it is on from the idle status.

States: `ST_IDLE`, `ST_CLK_UP`, `ST_SAVE`, `ST_BUS_IDLE`, `ST_SW_SET`, `ST_SW_POLL`, `ST_BUS_WAKE`, `ST_RESTORE`, `ST_CLK_DN` and `ST_FIN`.

Transitions:
- `ST_IDLE` goes to `ST_FIN` on a request for the state the domain is already in, and to `ST_CLK_UP` on any other valid request.
- `ST_CLK_UP` goes to `ST_SAVE` for power-down, and to `ST_SW_SET` for power-up.
- `ST_SAVE` goes to `ST_BUS_IDLE` on `qos_ack`.
- `ST_BUS_IDLE` goes to `ST_SW_SET` once acknowledge and idle status are both high.
- `ST_SW_SET` goes to `ST_SW_POLL` when the settle count runs out.
- `ST_SW_POLL` goes to `ST_BUS_WAKE` on a status match during power-up. It goes to `ST_CLK_DN` on a status match during power-down, or on timeout.
- `ST_BUS_WAKE` goes to `ST_RESTORE` once acknowledge and idle status are both low.
- `ST_RESTORE` goes to `ST_CLK_DN` on `qos_ack`.
- `ST_CLK_DN` goes to `ST_FIN` once every clock is released.
- `ST_FIN` goes back to `ST_IDLE`.

Phases the domain lacks are skipped, and the transition goes straight to the next phase that exists.

Top module: `pwr_dom_seq`

## Requirements
- R1: After reset, busy, done, fault, qos_save, qos_restore, idle_req, pwr_off and every clk_force bit are 0.
- R2: A request is taken only in idle, and only when exactly one of req_on and req_off is high. Both high together, or any request while busy is high, has no effect.
- R3: A request for the state the domain is already in does nothing else: done pulses in the cycle after the request is taken, and busy falls one cycle later.
- R4: After a request is taken, the clk_force bits rise one per cycle, lowest bit first. They stay all high through every phase. In the release phase they fall one per cycle, highest bit first, and done follows once all of them are low.
- R5: Power-down order is fixed. First qos_save is held high until qos_ack. Next idle_req rises, and the block waits for idle_ack and idle_stat both high. Only then does pwr_off rise to 1 (1 means off).
- R6: Power-up order is fixed. First pwr_off falls to 0 and the status confirms on. Next idle_req falls, and the block waits for idle_ack and idle_stat both low. Finally qos_restore is held high until qos_ack.
- R7: After pwr_off changes, the status is not sampled until max(N,1) cycles have passed. N is the power-down count for power-down and the power-up count for power-up.
- R8: pwr_stat reads 1 for off and 0 for on, and is polled until it matches the target. If it has not matched after 256 polls, fault is set, any remaining bus and QoS phases are skipped, the clocks are released, and done pulses. fault clears when the next request is taken.
- R9: With cfg_we high, cfg_sel 0 writes the power-down count and cfg_sel 1 writes the power-up count. Both reset to 24.
- R10: With HAS_SWITCH = 0, pwr_off stays 0 and the switch phase is skipped in both directions.
- R11: With HAS_STATUS = 0, the domain counts as on when idle_stat is 0 and as off when it is 1. This decides both whether a request does anything and when the switch phase ends.
- R12: done is high for exactly one cycle per taken request, and busy is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_on | input | 1 | Pulse that requests power-up |
| req_off | input | 1 | Pulse that requests power-down |
| cfg_we | input | 1 | Write strobe for a transition count |
| cfg_sel | input | 1 | Selects the count: 0 for power-down, 1 for power-up |
| cfg_wdata | input | CNT_W | Count value to write |
| qos_ack | input | 1 | QoS store acknowledges a save or restore |
| idle_ack | input | 1 | Bus interface acknowledges the idle request level |
| idle_stat | input | 1 | Bus interface is idle |
| pwr_stat | input | 1 | Switch status, 1 = off |
| busy | output | 1 | A request is being handled |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | The last sequence timed out waiting for status |
| qos_save | output | 1 | Save-context request, held until acknowledged |
| qos_restore | output | 1 | Restore-context request, held until acknowledged |
| idle_req | output | 1 | Bus idle request level |
| pwr_off | output | 1 | Power switch control, 1 = off |
| clk_force | output | NUM_CLK | Forced clock enables for the domain |

## Verification
The bench goes after the following corner cases:
- **Zero up count.** The settle phase still has to last one cycle. A design that underflows its timer would skip the settle or wait about 2^32 cycles.
- **Status stuck on off.** The status must be polled exactly 256 times before the fault. A design that counts the window wrong, or forgets to skip the bus wake and restore phases, drifts from the cycle model.
- **Request noise while busy, and both requests together.** A design that re-arms on these would restart the sequence or leave idle.
- **Repeated request.** It must finish in one cycle. A design that compares against the wrong status encoding would instead run a full sequence.
- **Domain with neither switch nor status bit.** It must never touch pwr_off and must judge its state from the idle status.

// File: rtl/pds_pkg.sv
package pds_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLK_UP,
        ST_SAVE,
        ST_BUS_IDLE,
        ST_SW_SET,
        ST_SW_POLL,
        ST_BUS_WAKE,
        ST_RESTORE,
        ST_CLK_DN,
        ST_FIN
    } pds_state_e;

endpackage

// File: rtl/pds_timer.sv
module pds_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/pds_clkhold.sv
module pds_clkhold #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grab,
    input  logic         drop,
    output logic [N-1:0] force_en,
    output logic         all_on,
    output logic         all_off
);

    generate
        if (N == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    force_en <= '0;
                end else if (grab) begin
                    force_en <= 1'b1;
                end else if (drop) begin
                    force_en <= 1'b0;
                end
            end
        end else begin : g_chain
            // lowest enable first on grab, highest enable first on drop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    force_en <= '0;
                end else if (grab) begin
                    force_en <= {force_en[N-2:0], 1'b1};
                end else if (drop) begin
                    force_en <= {1'b0, force_en[N-1:1]};
                end
            end
        end
    endgenerate

    assign all_on  = force_en[N-1];
    assign all_off = ~|force_en;

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm
    import pds_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int TIMEOUT_CYC = 256,
    parameter bit HAS_SWITCH  = 1'b1,
    parameter bit HAS_STATUS  = 1'b1,
    parameter bit HAS_IDLE    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_on,
    input  logic             req_off,
    input  logic             qos_ack,
    input  logic             idle_ack,
    input  logic             idle_stat,
    input  logic             pwr_stat,
    input  logic             clk_all_on,
    input  logic             clk_all_off,
    input  logic [CNT_W-1:0] tmr_cnt,
    input  logic [CNT_W-1:0] dn_cnt,
    input  logic [CNT_W-1:0] up_cnt,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic             qos_save,
    output logic             qos_restore,
    output logic             idle_req,
    output logic             pwr_off,
    output logic             clk_grab,
    output logic             clk_drop,
    output logic             tmr_load,
    output logic             tmr_dec,
    output logic [CNT_W-1:0] tmr_val
);

    localparam logic [CNT_W-1:0] POLL_LOAD = CNT_W'(TIMEOUT_CYC - 1);
    localparam pds_state_e UP_AFTER_SW  = HAS_IDLE ? ST_BUS_WAKE : ST_RESTORE;
    localparam pds_state_e UP_FIRST     = HAS_SWITCH ? ST_SW_SET : UP_AFTER_SW;
    localparam pds_state_e DN_AFTER_BUS = HAS_SWITCH ? ST_SW_SET : ST_CLK_DN;
    localparam pds_state_e DN_AFTER_QOS = HAS_IDLE ? ST_BUS_IDLE : DN_AFTER_BUS;

    pds_state_e st, nxt;
    logic       tgt_on_q;
    logic       fault_q;
    logic       idle_q;
    logic       pwr_q;
    logic       go;
    logic       dom_on;
    logic       stat_ok;
    logic       poll_expired;

    assign go     = req_on ^ req_off;
    assign dom_on = HAS_STATUS ? !pwr_stat : (HAS_IDLE ? !idle_stat : !pwr_q);
    assign stat_ok = HAS_STATUS ? (pwr_stat == !tgt_on_q) : (idle_stat == !tgt_on_q);
    assign poll_expired = (st == ST_SW_POLL) && !stat_ok && (tmr_cnt == '0);

    // next-state logic
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:     if (go) nxt = (req_on == dom_on) ? ST_FIN : ST_CLK_UP;
            ST_CLK_UP:   if (clk_all_on) nxt = tgt_on_q ? UP_FIRST : ST_SAVE;
            ST_SAVE:     if (qos_ack) nxt = DN_AFTER_QOS;
            ST_BUS_IDLE: if (idle_ack && idle_stat) nxt = DN_AFTER_BUS;
            ST_SW_SET:   if (tmr_cnt <= CNT_W'(1)) nxt = ST_SW_POLL;
            ST_SW_POLL: begin
                if (stat_ok)           nxt = tgt_on_q ? UP_AFTER_SW : ST_CLK_DN;
                else if (poll_expired) nxt = ST_CLK_DN;
            end
            ST_BUS_WAKE: if (!idle_ack && !idle_stat) nxt = ST_RESTORE;
            ST_RESTORE:  if (qos_ack) nxt = ST_CLK_DN;
            ST_CLK_DN:   if (clk_all_off) nxt = ST_FIN;
            ST_FIN:      nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // context registers: target, fault, idle request level, switch control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_on_q <= 1'b0;
            fault_q  <= 1'b0;
            idle_q   <= 1'b0;
            pwr_q    <= 1'b0;
        end else begin
            if (st == ST_IDLE && go) begin
                tgt_on_q <= req_on;
                fault_q  <= 1'b0;
            end
            if (poll_expired) fault_q <= 1'b1;
            if (nxt == ST_BUS_IDLE && st != ST_BUS_IDLE) idle_q <= 1'b1;
            if (nxt == ST_BUS_WAKE && st != ST_BUS_WAKE) idle_q <= 1'b0;
            if (nxt == ST_SW_SET && st != ST_SW_SET)     pwr_q  <= !tgt_on_q;
        end
    end

    // outputs
    always_comb begin
        busy        = (st != ST_IDLE);
        done        = (st == ST_FIN);
        qos_save    = (st == ST_SAVE);
        qos_restore = (st == ST_RESTORE);
        clk_grab    = (st == ST_CLK_UP);
        clk_drop    = (st == ST_CLK_DN);
        fault       = fault_q;
        idle_req    = idle_q;
        pwr_off     = pwr_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        if (nxt == ST_SW_SET && st != ST_SW_SET) begin
            tmr_load = 1'b1;
            tmr_val  = tgt_on_q ? up_cnt : dn_cnt;
        end else if (st == ST_SW_SET && nxt == ST_SW_POLL) begin
            tmr_load = 1'b1;
            tmr_val  = POLL_LOAD;
        end
        tmr_dec = !tmr_load && (st == ST_SW_SET || st == ST_SW_POLL);
    end

endmodule

// File: rtl/pwr_dom_seq.sv
module pwr_dom_seq #(
    parameter int NUM_CLK     = 3,
    parameter int CNT_W       = 32,
    parameter int DEF_CNT     = 24,
    parameter int TIMEOUT_CYC = 256,
    parameter bit HAS_SWITCH  = 1'b1,
    parameter bit HAS_STATUS  = 1'b1,
    parameter bit HAS_IDLE    = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_on,
    input  logic               req_off,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [CNT_W-1:0]   cfg_wdata,
    input  logic               qos_ack,
    input  logic               idle_ack,
    input  logic               idle_stat,
    input  logic               pwr_stat,
    output logic               busy,
    output logic               done,
    output logic               fault,
    output logic               qos_save,
    output logic               qos_restore,
    output logic               idle_req,
    output logic               pwr_off,
    output logic [NUM_CLK-1:0] clk_force
);

    localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(DEF_CNT);

    logic [CNT_W-1:0] dn_cnt_q, up_cnt_q;
    logic [CNT_W-1:0] tmr_cnt, tmr_val;
    logic             tmr_load, tmr_dec;
    logic             clk_grab, clk_drop, clk_all_on, clk_all_off;

    // transition count registers: select 0 = down, 1 = up
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dn_cnt_q <= RST_CNT;
            up_cnt_q <= RST_CNT;
        end else if (cfg_we) begin
            if (cfg_sel) up_cnt_q <= cfg_wdata;
            else         dn_cnt_q <= cfg_wdata;
        end
    end

    pds_fsm #(
        .CNT_W      (CNT_W),
        .TIMEOUT_CYC(TIMEOUT_CYC),
        .HAS_SWITCH (HAS_SWITCH),
        .HAS_STATUS (HAS_STATUS),
        .HAS_IDLE   (HAS_IDLE)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_on     (req_on),
        .req_off    (req_off),
        .qos_ack    (qos_ack),
        .idle_ack   (idle_ack),
        .idle_stat  (idle_stat),
        .pwr_stat   (pwr_stat),
        .clk_all_on (clk_all_on),
        .clk_all_off(clk_all_off),
        .tmr_cnt    (tmr_cnt),
        .dn_cnt     (dn_cnt_q),
        .up_cnt     (up_cnt_q),
        .busy       (busy),
        .done       (done),
        .fault      (fault),
        .qos_save   (qos_save),
        .qos_restore(qos_restore),
        .idle_req   (idle_req),
        .pwr_off    (pwr_off),
        .clk_grab   (clk_grab),
        .clk_drop   (clk_drop),
        .tmr_load   (tmr_load),
        .tmr_dec    (tmr_dec),
        .tmr_val    (tmr_val)
    );

    pds_timer #(.W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .dec     (tmr_dec),
        .load_val(tmr_val),
        .cnt     (tmr_cnt)
    );

    pds_clkhold #(.N(NUM_CLK)) u_clk (
        .clk     (clk),
        .rst_n   (rst_n),
        .grab    (clk_grab),
        .drop    (clk_drop),
        .force_en(clk_force),
        .all_on  (clk_all_on),
        .all_off (clk_all_off)
    );

endmodule

// File: rtl/pds_checker.sv
module pds_checker #(
    parameter int NUM_CLK  = 3,
    parameter bit HAS_IDLE = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_on,
    input logic               req_off,
    input logic               busy,
    input logic               done,
    input logic               qos_save,
    input logic               qos_restore,
    input logic               idle_req,
    input logic               pwr_off,
    input logic [NUM_CLK-1:0] clk_force
);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r4_clk_full_at_switch: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pwr_off) |-> (&clk_force));

    a_r4_clk_free_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (clk_force == '0));

    a_r5_save_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_req) |-> $past(qos_save));

    a_r5_idle_before_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_off) |-> (idle_req || !HAS_IDLE));

    a_r6_release_before_restore: assert property (@(posedge clk) disable iff (!rst_n)
        qos_restore |-> !idle_req);

    a_r2_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(req_on ^ req_off)) |=> !busy);

endmodule

bind pwr_dom_seq pds_checker #(.NUM_CLK(NUM_CLK), .HAS_IDLE(HAS_IDLE)) u_pds_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_on     (req_on),
    .req_off    (req_off),
    .busy       (busy),
    .done       (done),
    .qos_save   (qos_save),
    .qos_restore(qos_restore),
    .idle_req   (idle_req),
    .pwr_off    (pwr_off),
    .clk_force  (clk_force)
);

// File: tb/pwr_dom_seq_test.sv
`timescale 1ns/100ps
module pwr_dom_seq_test;

    localparam int NCLK = 3;
    localparam int CW   = 32;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic req_on = 1'b0, req_off = 1'b0;
    logic cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [CW-1:0] cfg_wdata = '0;
    logic qos_ack, idle_ack, idle_stat, pwr_stat;
    logic busy, done, fault, qos_save, qos_restore, idle_req, pwr_off;
    logic [NCLK-1:0] clk_force;

    pwr_dom_seq #(.NUM_CLK(NCLK)) uut (
        .clk(clk), .rst_n(rst_n), .req_on(req_on), .req_off(req_off),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .qos_ack(qos_ack), .idle_ack(idle_ack), .idle_stat(idle_stat), .pwr_stat(pwr_stat),
        .busy(busy), .done(done), .fault(fault), .qos_save(qos_save),
        .qos_restore(qos_restore), .idle_req(idle_req), .pwr_off(pwr_off),
        .clk_force(clk_force)
    );

    // second domain: no switch, no status bit
    logic req_on2 = 1'b0, req_off2 = 1'b0;
    logic qack2, iack2, istat2;
    logic busy2, done2, fault2, qs2, qr2, ireq2, poff2;
    logic [1:0] cf2;

    pwr_dom_seq #(.NUM_CLK(2), .HAS_SWITCH(1'b0), .HAS_STATUS(1'b0)) uut2 (
        .clk(clk), .rst_n(rst_n), .req_on(req_on2), .req_off(req_off2),
        .cfg_we(1'b0), .cfg_sel(1'b0), .cfg_wdata('0),
        .qos_ack(qack2), .idle_ack(iack2), .idle_stat(istat2), .pwr_stat(1'b0),
        .busy(busy2), .done(done2), .fault(fault2), .qos_save(qs2),
        .qos_restore(qr2), .idle_req(ireq2), .pwr_off(poff2), .clk_force(cf2)
    );

    // responders
    logic [3:0] pipe;
    logic stuck = 1'b0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qos_ack <= 1'b0; idle_ack <= 1'b0; idle_stat <= 1'b0;
            pipe <= '0; pwr_stat <= 1'b0;
            qack2 <= 1'b0; iack2 <= 1'b0; istat2 <= 1'b0;
        end else begin
            qos_ack   <= (qos_save || qos_restore) && !qos_ack;
            idle_ack  <= idle_req;
            idle_stat <= idle_ack;
            pipe      <= {pipe[2:0], pwr_off};
            if (!stuck) pwr_stat <= pipe[2];
            qack2  <= (qs2 || qr2) && !qack2;
            iack2  <= ireq2;
            istat2 <= iack2;
        end
    end

    int vec = 0, bad = 0;
    string tag = "R1";
    logic e_busy = 0, e_done = 0, e_qs = 0, e_qr = 0, e_idle = 0, e_pwr = 0, e_fault = 0;
    logic [NCLK-1:0] e_force = '0;
    bit m_on = 1'b1;
    bit noise = 1'b0;

    function automatic logic [NCLK-1:0] mask(int k);
        return NCLK'((1 << k) - 1);
    endfunction

    task automatic tick();
        logic [NCLK+6:0] act, exp;
        @(negedge clk);
        act = {busy, done, qos_save, qos_restore, idle_req, pwr_off, fault, clk_force};
        exp = {e_busy, e_done, e_qs, e_qr, e_idle, e_pwr, e_fault, e_force};
        vec++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (busy,done,save,restore,idle,pwr,fault,clk)", tag, act, exp);
        end
        if (noise) req_on = vec[0];
    endtask

    task automatic chk(input bit ok, input string t, input int a, input int e);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", t, a, e);
        end
    endtask

    task automatic run(input bit want_on, input int nset, input bit exp_to);
        bit to = 1'b0;
        if (want_on) req_on = 1'b1; else req_off = 1'b1;
        e_fault = 1'b0;
        e_busy  = 1'b1;
        if (want_on == m_on) begin
            e_done = 1'b1; tick();
            req_on = 1'b0; req_off = 1'b0;
            e_done = 1'b0; e_busy = 1'b0; tick();
            return;
        end
        for (int k = 0; k <= NCLK; k++) begin
            e_force = mask(k); tick();
            if (k == 0) begin req_off = 1'b0; if (!noise) req_on = 1'b0; end
        end
        if (!want_on) begin
            e_qs = 1'b1;
            do tick(); while (!qos_ack);
            e_qs = 1'b0; e_idle = 1'b1;
            do tick(); while (!(idle_ack && idle_stat));
        end
        e_pwr = !want_on;
        for (int j = 0; j < ((nset > 1) ? nset : 1); j++) tick();
        for (int i = 0; i < 256; i++) begin
            tick();
            if (pwr_stat == !want_on) break;
            if (i == 255) to = 1'b1;
        end
        if (to) e_fault = 1'b1;
        else if (want_on) begin
            e_idle = 1'b0;
            do tick(); while (idle_ack || idle_stat);
            e_qr = 1'b1;
            do tick(); while (!qos_ack);
            e_qr = 1'b0;
        end
        noise = 1'b0; req_on = 1'b0;
        for (int k = NCLK; k >= 0; k--) begin
            e_force = mask(k); tick();
        end
        e_done = 1'b1; tick();
        e_done = 1'b0; e_busy = 1'b0; tick();
        chk(to == exp_to, "R8 timeout outcome", int'(to), int'(exp_to));
        if (!to) m_on = want_on;
    endtask

    task automatic run2(input bit want_on, input bit noop, input string t);
        int n = 0;
        bit seen = 1'b0, leak = 1'b0;
        if (want_on) req_on2 = 1'b1; else req_off2 = 1'b1;
        @(negedge clk);
        req_on2 = 1'b0; req_off2 = 1'b0;
        while (!seen && n < 80) begin
            if (poff2) leak = 1'b1;
            if (done2) seen = 1'b1;
            else begin @(negedge clk); n++; end
        end
        chk(seen, {t, " R12 done seen"}, int'(seen), 1);
        chk(!leak, "R10 pwr_off stays 0", int'(leak), 0);
        if (noop) chk(n == 0, "R11 no-op from idle status", n, 0);
        else      chk(n > 0, "R11 full run from idle status", n, 1);
        chk(ireq2 == !want_on, "R11 idle_req level", int'(ireq2), int'(!want_on));
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tag = "R1 reset";
        repeat (3) tick();

        tag = "R5 R7 R9 default down count";
        run(1'b0, 24, 1'b0);

        tag = "R3 repeated off";
        run(1'b0, 0, 1'b0);

        tag = "R9 count write";
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'd2; tick();
        cfg_sel = 1'b1; cfg_wdata = 32'd0; tick();
        cfg_we = 1'b0;

        tag = "R6 R7 up with zero count";
        run(1'b1, 0, 1'b0);

        tag = "R2 both requests";
        req_on = 1'b1; req_off = 1'b1;
        tick(); tick();
        req_on = 1'b0; req_off = 1'b0;
        tick();

        tag = "R2 R4 requests while busy";
        noise = 1'b1;
        run(1'b0, 2, 1'b0);

        tag = "R8 status stuck off";
        stuck = 1'b1;
        run(1'b1, 0, 1'b1);
        stuck = 1'b0;
        repeat (8) tick();
        m_on = 1'b1;

        tag = "R8 fault cleared on next request";
        run(1'b0, 2, 1'b0);
        tag = "R6 second up";
        run(1'b1, 0, 1'b0);

        run2(1'b0, 1'b0, "R10 down no switch");
        run2(1'b0, 1'b1, "R3 R11 repeat down");
        run2(1'b1, 1'b0, "R10 up no switch");

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule